// File: doc/BRIEF.md
# Load/Store Address Steering with Two Mapped Devices

This block sits between a processor's data port and two kinds of targets: a small word-wide data RAM and a pair of device registers. A fixed window at the very top of the byte address space is kept for devices. Every load or store address is decoded. Stores landing on the output device's word update that device's register and never reach the RAM. Loads landing on a device word return that device's value through a read multiplexer in place of RAM data.

The processor side is a single-cycle synchronous port that carries a word address, so byte address = word address × 4. The I/O window spans byte addresses 0xFFFFFF00 to 0xFFFFFFFF (word addresses 0x3FFFFFC0 to 0x3FFFFFFF). The output device sits at byte 0xFFFFFFF4 (word 0x3FFFFFFD) and drives a port of the block. The input device sits at byte 0xFFFFFFF8 (word 0x3FFFFFFE) and returns the value on an input port. Every address outside the window goes to the RAM. The RAM is indexed by the low six word-address bits, so it repeats across the whole lower region. Load data is registered and appears one clock after the load.

Top module: `mmio_fabric`

## Requirements
- R1: While reset is asserted, and after it is released but before any store, `cpu_rdata` and `dev1_out` are zero.
- R2: A store to a word address outside the window writes RAM word `cpu_waddr[5:0]`. A later load from any address with the same low six bits, outside the window, returns that value.
- R3: A store to word 0x3FFFFFFD sets `dev1_out` to the store data after the next rising edge, and it leaves every RAM word unchanged. `dev1_out` changes only on such a store.
- R4: A load from word 0x3FFFFFFD returns the current `dev1_out` value.
- R5: A load from word 0x3FFFFFFE returns the value of `dev2_in` seen at the clock edge that takes the load.
- R6: A store to word 0x3FFFFFFE, or to any other word inside the window, changes neither `dev1_out` nor any RAM word.
- R7: A load from a window word other than 0x3FFFFFFD and 0x3FFFFFFE returns zero.
- R8: Per store, at most one of the RAM write enable and the output-device write enable is active.
- R9: `cpu_rdata` keeps its value on every cycle without a load.
- R10: A load and a store in the same cycle return the target's contents from before the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_waddr | input | 30 | Word address of the access (byte address bits 31:2) |
| cpu_wdata | input | 32 | Store data |
| cpu_we | input | 1 | Store request |
| cpu_re | input | 1 | Load request |
| cpu_rdata | output | 32 | Load data, valid the cycle after the load |
| dev1_out | output | 32 | Output device register |
| dev2_in | input | 32 | Input device value |

## Verification
Two results are due one rising edge after the request: load data on `cpu_rdata`, and the new `dev1_out` after a store to the output device. The bench drives each access on a falling edge, lets exactly one rising edge pass, and then compares both outputs 1 ns later. The expected values come from a reference model that is updated only after the expected load value is captured, so a same-cycle store never affects the expected load data. Unmapped window stores and device stores are followed by loads of the RAM and of the output device, so any stray write would show up at the ports.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_DEV1 = 2'd1,
    TGT_DEV2 = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  localparam int unsigned NUM_WR_TGT = 2;
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_pkg::*;
#(
  parameter int unsigned WA_W      = 30,
  parameter int unsigned WIN_WBITS = 6,
  parameter logic [WA_W-1:0] DEV1_WADDR = 30'h3FFFFFFD,
  parameter logic [WA_W-1:0] DEV2_WADDR = 30'h3FFFFFFE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WA_W-1:0] waddr,
  input  logic            we,
  output tgt_e            tgt,
  output logic            ram_we,
  output logic            dev1_we
);
  logic in_win;
  logic hit_dev1;
  logic hit_dev2;
  logic [NUM_WR_TGT-1:0] we_vec;

  assign in_win   = &waddr[WA_W-1:WIN_WBITS];
  assign hit_dev1 = (waddr == DEV1_WADDR);
  assign hit_dev2 = (waddr == DEV2_WADDR);

  always_comb begin
    tgt = TGT_RAM;
    if (in_win) begin
      if (hit_dev1)      tgt = TGT_DEV1;
      else if (hit_dev2) tgt = TGT_DEV2;
      else               tgt = TGT_NONE;
    end
  end

  always_comb begin
    for (int t = 0; t < NUM_WR_TGT; t++) begin
      we_vec[t] = we && (tgt == tgt_e'(t));
    end
  end

  assign ram_we  = we_vec[TGT_RAM];
  assign dev1_we = we_vec[TGT_DEV1];

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, dev1_we})); // R8
endmodule

// File: rtl/mmio_ram.sv
module mmio_ram #(
  parameter int unsigned DW    = 32,
  parameter int unsigned WORDS = 64,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [WORDS];
  logic [WORDS-1:0] wen;

  for (genvar w = 0; w < WORDS; w++) begin : g_wen
    assign wen[w] = we && (idx == IW'(w));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WORDS; i++) begin
      if (wen[i]) mem_q[i] <= wdata;
    end
  end

  assign rdata = mem_q[idx];
endmodule

// File: rtl/mmio_out_reg.sv
module mmio_out_reg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_d;

  always_comb begin
    q_d = q;
    if (we) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  AST_DEV1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R3
endmodule

// File: rtl/mmio_rdmux.sv
module mmio_rdmux
  import mmio_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          re,
  input  tgt_e          tgt,
  input  logic [DW-1:0] ram_q,
  input  logic [DW-1:0] dev1_q,
  input  logic [DW-1:0] dev2_q,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] sel_data;
  logic [DW-1:0] rdata_d;

  always_comb begin
    unique case (tgt)
      TGT_RAM:  sel_data = ram_q;
      TGT_DEV1: sel_data = dev1_q;
      TGT_DEV2: sel_data = dev2_q;
      default:  sel_data = '0;
    endcase
  end

  always_comb begin
    rdata_d = rdata;
    if (re) rdata_d = sel_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata)); // R9
endmodule

// File: rtl/mmio_fabric.sv
module mmio_fabric
  import mmio_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned RAM_WORDS = 64,
  parameter int unsigned WIN_BITS  = 8,
  parameter logic [AW-1:0] DEV1_ADDR = 32'hFFFF_FFF4,
  parameter logic [AW-1:0] DEV2_ADDR = 32'hFFFF_FFF8,
  localparam int unsigned WA_W      = AW - 2,
  localparam int unsigned WIN_WBITS = WIN_BITS - 2,
  localparam int unsigned IW        = $clog2(RAM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WA_W-1:0] cpu_waddr,
  input  logic [DW-1:0]   cpu_wdata,
  input  logic            cpu_we,
  input  logic            cpu_re,
  output logic [DW-1:0]   cpu_rdata,
  output logic [DW-1:0]   dev1_out,
  input  logic [DW-1:0]   dev2_in
);
  localparam logic [WA_W-1:0] DEV1_WADDR = DEV1_ADDR[AW-1:2];
  localparam logic [WA_W-1:0] DEV2_WADDR = DEV2_ADDR[AW-1:2];

  logic [1:0]    rst_sync;
  logic          rst_i_n;
  tgt_e          tgt;
  logic          ram_we;
  logic          dev1_we;
  logic [DW-1:0] ram_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  mmio_decode #(
    .WA_W(WA_W), .WIN_WBITS(WIN_WBITS),
    .DEV1_WADDR(DEV1_WADDR), .DEV2_WADDR(DEV2_WADDR)
  ) u_decode (
    .clk(clk), .rst_n(rst_i_n), .waddr(cpu_waddr), .we(cpu_we),
    .tgt(tgt), .ram_we(ram_we), .dev1_we(dev1_we)
  );

  mmio_ram #(.DW(DW), .WORDS(RAM_WORDS)) u_ram (
    .clk(clk), .we(ram_we), .idx(cpu_waddr[IW-1:0]),
    .wdata(cpu_wdata), .rdata(ram_q)
  );

  mmio_out_reg #(.DW(DW)) u_dev1 (
    .clk(clk), .rst_n(rst_i_n), .we(dev1_we),
    .wdata(cpu_wdata), .q(dev1_out)
  );

  mmio_rdmux #(.DW(DW)) u_rdmux (
    .clk(clk), .rst_n(rst_i_n), .re(cpu_re), .tgt(tgt),
    .ram_q(ram_q), .dev1_q(dev1_out), .dev2_q(dev2_in), .rdata(cpu_rdata)
  );

  AST_WIN_NO_RAM_WRITE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cpu_we && (&cpu_waddr[WA_W-1:WIN_WBITS])) |-> !ram_we); // R6
  AST_DEV1_STORE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cpu_we && cpu_waddr == DEV1_WADDR) |=> dev1_out == $past(cpu_wdata)); // R3
  AST_DEV1_LOAD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cpu_re && cpu_waddr == DEV1_WADDR) |=> cpu_rdata == $past(dev1_out)); // R4
  AST_DEV2_LOAD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cpu_re && cpu_waddr == DEV2_WADDR) |=> cpu_rdata == $past(dev2_in)); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cpu_re && (&cpu_waddr[WA_W-1:WIN_WBITS]) && cpu_waddr != DEV1_WADDR
     && cpu_waddr != DEV2_WADDR) |=> cpu_rdata == '0); // R7
endmodule

// File: tb/mmio_fabric_test.sv
module mmio_fabric_test;
  localparam logic [29:0] D1 = 30'h3FFFFFFD;
  localparam logic [29:0] D2 = 30'h3FFFFFFE;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [29:0] cpu_waddr;
  logic [31:0] cpu_wdata;
  logic        cpu_we;
  logic        cpu_re;
  logic [31:0] cpu_rdata;
  logic [31:0] dev1_out;
  logic [31:0] dev2_in;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] mem_m [64];
  logic [31:0] dev1_m  = '0;
  logic [31:0] rdata_m = '0;

  always #5 clk = ~clk;

  mmio_fabric uut (
    .clk(clk), .rst_n(rst_n), .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata),
    .dev1_out(dev1_out), .dev2_in(dev2_in)
  );

  function automatic bit in_win(logic [29:0] a);
    return &a[29:6];
  endfunction

  function automatic logic [31:0] exp_load(logic [29:0] a, logic [31:0] d2);
    if (!in_win(a)) return mem_m[a[5:0]];
    if (a == D1) return dev1_m;
    if (a == D2) return d2;
    return '0;
  endfunction

  function automatic string load_tag(logic [29:0] a);
    if (!in_win(a)) return "R2";
    if (a == D1) return "R4";
    if (a == D2) return "R5";
    return "R7";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(logic [29:0] a, logic [31:0] d, bit we, bit re,
                    logic [31:0] d2, string tag);
    logic [31:0] exp_r;
    string rt, dt;
    @(negedge clk);
    cpu_waddr = a; cpu_wdata = d; cpu_we = we; cpu_re = re; dev2_in = d2;
    exp_r = re ? exp_load(a, d2) : rdata_m;
    rt = (tag != "") ? tag : (re ? load_tag(a) : "R9");
    dt = (we && in_win(a) && a != D1) ? "R6" : "R3";
    if (we) begin
      if (!in_win(a)) mem_m[a[5:0]] = d;
      else if (a == D1) dev1_m = d;
    end
    rdata_m = exp_r;
    @(posedge clk);
    #1;
    check(rt, cpu_rdata, exp_r);
    check(dt, dev1_out, dev1_m);
    @(negedge clk);
    cpu_we = 1'b0; cpu_re = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [29:0] a;
    int r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cpu_waddr = '0; cpu_wdata = '0; cpu_we = 1'b0;
    cpu_re = 1'b0; dev2_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", cpu_rdata, 32'h0);
    check("R1", dev1_out, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", cpu_rdata, 32'h0);
    check("R1", dev1_out, 32'h0);

    // R2: fill every RAM word through aliased lower addresses
    for (int i = 0; i < 64; i++)
      op({$urandom} [29:0] & 30'h1FFFFFC0 | 30'(i), $urandom, 1'b1, 1'b0, '0, "R2");
    op(30'h0000_0005, '0, 1'b0, 1'b1, '0, "R2");
    op(30'h2ABC_DEC5, '0, 1'b0, 1'b1, '0, "R2");

    // R3 and R4: output device store then load
    op(D1, 32'hCAFE_0001, 1'b1, 1'b0, '0, "");
    op(D1, '0, 1'b0, 1'b1, '0, "R4");
    op(30'h0000_003D, '0, 1'b0, 1'b1, '0, "R3");
    // R6: stores to input device and unmapped window word
    op(D2, 32'hDEAD_BEEF, 1'b1, 1'b0, 32'h1111_2222, "");
    op(30'h3FFFFFC0, 32'h5555_AAAA, 1'b1, 1'b0, '0, "");
    op(30'h0000_003E, '0, 1'b0, 1'b1, '0, "R6");
    op(30'h0000_0000, '0, 1'b0, 1'b1, '0, "R6");
    op(D1, '0, 1'b0, 1'b1, '0, "R6");
    // R5 and R7
    op(D2, '0, 1'b0, 1'b1, 32'h0BAD_F00D, "R5");
    op(30'h3FFFFFFF, '0, 1'b0, 1'b1, 32'hFFFF_FFFF, "R7");
    // R9: idle cycles keep load data
    op(30'h0000_0011, '0, 1'b0, 1'b0, '0, "R9");
    // R10: same-cycle load and store
    op(30'h0000_0007, 32'h7777_0007, 1'b1, 1'b1, '0, "R10");
    op(30'h0000_0007, '0, 1'b0, 1'b1, '0, "R10");
    op(D1, 32'h1234_5678, 1'b1, 1'b1, '0, "R10");
    op(D1, '0, 1'b0, 1'b1, '0, "R10");

    for (int n = 0; n < 800; n++) begin
      r = $urandom % 10;
      if (r < 5) begin
        a = 30'($urandom);
        if (in_win(a)) a[29] = 1'b0;
      end else if (r < 7) a = D1;
      else if (r < 9) a = D2;
      else begin
        a = {24'hFFFFFF, 6'($urandom)};
        if (a == D1 || a == D2) a = 30'h3FFFFFC3;
      end
      op(a, $urandom, 1'($urandom), 1'($urandom), $urandom, "");
    end

    done = 1;
    summary();
  end
endmodule